// File: doc/BRIEF.md
# Sixteen-Pin Bidirectional Port Register Bank

This block holds the configuration and output state of sixteen bidirectional digital pins. The pins are split into four groups of four, and each group has one 8-bit register on a simple special-function-register bus. The upper nibble of each register sets whether each of the group's pins is an output. The lower nibble is the value those output pins drive.

A single chip-wide enable input sits over every driver. After reset every pin is set up as an output, but none is driven. Firmware first sets up direction and data, then raises the enable. From then on, each pin whose direction bit is 1 drives its latched value, and the other pins are left undriven.

Reading a register returns the stored direction bits in the upper nibble. The lower nibble carries the live pin levels, passed through a two-flop synchronizer. An output pin therefore reads back the level it actually has on the pad. The pad is modelled as an enable/value pair (`pin_oe`, `pin_do`) plus a sampled level (`pin_di`).

Top module: `gpio_bank`

## Requirements
- R1: Synchronous active-high reset sets every direction bit to 1 and every data-latch bit to 0, so each register reads 0xF0 while all pins sit low.
- R2: While `port_en` is 0, every bit of `pin_oe` is 0, whatever the direction bits hold.
- R3: While `port_en` is 1, `pin_oe[i]` equals the direction bit of pin i, and `pin_do[i]` always equals the latch bit of pin i.
- R4: A write strobe at address 0x80, 0x90, 0xA0 or 0xB0 updates group 0, 1, 2 or 3 (pins 4k to 4k+3) on the next clock edge. Write bit 4+n becomes the direction bit of pin 4k+n, and write bit n becomes its latch bit.
- R5: A read of a group address returns that group's stored direction bits in bits 7:4, combinationally from the address.
- R6: Bits 3:0 of a group read return `pin_di` for that group's pins, through two register stages. A level change first appears after the second rising edge that follows it.
- R7: An output pin reads back the level present on the pad, including while it is driven.
- R8: A write strobe at any address other than the four group addresses changes no direction or latch bit.
- R9: A read of any address other than the four group addresses returns 0x00.
- R10: Toggling `port_en` leaves the stored direction and latch bits untouched, so re-enabling restores the same drive pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Chip-wide pad drive enable |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the current address |
| pin_di | input | 16 | Sampled pad levels |
| pin_oe | output | 16 | Per-pin pad driver enable |
| pin_do | output | 16 | Per-pin pad driver value |

## Verification
The checker watches five things on every cycle: the held-off drivers while the enable is low, the match between group-0 drive enables and the direction nibble read back, the two-cycle input latency on group 0, the immediate effect of a group-0 write, and zero reads and inert writes at unmapped addresses. Some behaviours need the bench's scenarios to show them. These are the readback of driven outputs through the pad model, mixed input/output groups, the exact edge at which a forced input becomes visible, and the drive pattern being restored after the enable toggles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NUM_BANKS     = 4;
    localparam int PINS_PER_BANK = 4;
    localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 2 * PINS_PER_BANK;
    localparam int SYNC_STAGES   = 2;
    localparam int BASE_ADDR     = 'h80;
    localparam int ADDR_STRIDE   = 'h10;
    localparam int BANK_IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] idx;
    } bank_sel_t;

    typedef struct packed {
        logic [PINS_PER_BANK-1:0] dir;
        logic [PINS_PER_BANK-1:0] lat;
    } port_word_t;

    function automatic bank_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        bank_sel_t r;
        r = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (a == ADDR_W'(BASE_ADDR + k * ADDR_STRIDE)) begin
                r.hit = 1'b1;
                r.idx = BANK_IDX_W'(k);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output bank_sel_t            sel,
    output logic [NUM_BANKS-1:0] wr_en
);
    always_comb begin
        sel = decode_addr(addr);
        for (int k = 0; k < NUM_BANKS; k++) begin
            wr_en[k] = we && sel.hit && (sel.idx == BANK_IDX_W'(k));
        end
    end
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  port_word_t wdata,
    output port_word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.dir <= '1;
            q.lat <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                port_en,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic                sfr_we,
    input  logic [DATA_W-1:0]   sfr_wdata,
    output logic [DATA_W-1:0]   sfr_rdata,
    input  logic [NUM_PINS-1:0] pin_di,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_do
);
    bank_sel_t             sel;
    logic [NUM_BANKS-1:0]  wr_en;
    port_word_t            regs [NUM_BANKS];
    logic [NUM_PINS-1:0]   pin_sync;

    gpio_addr_dec u_dec (
        .addr  (sfr_addr),
        .we    (sfr_we),
        .sel   (sel),
        .wr_en (wr_en)
    );

    gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_di),
        .q   (pin_sync)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        gpio_port_reg u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en[g]),
            .wdata (port_word_t'(sfr_wdata)),
            .q     (regs[g])
        );
        assign pin_oe[g*PINS_PER_BANK +: PINS_PER_BANK] = regs[g].dir & {PINS_PER_BANK{port_en}};
        assign pin_do[g*PINS_PER_BANK +: PINS_PER_BANK] = regs[g].lat;
    end

    always_comb begin
        sfr_rdata = '0;
        if (sel.hit) begin
            sfr_rdata = {regs[sel.idx].dir,
                         pin_sync[int'(sel.idx)*PINS_PER_BANK +: PINS_PER_BANK]};
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                port_en,
    input logic [ADDR_W-1:0]   sfr_addr,
    input logic                sfr_we,
    input logic [DATA_W-1:0]   sfr_wdata,
    input logic [DATA_W-1:0]   sfr_rdata,
    input logic [NUM_PINS-1:0] pin_di,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_do
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    logic mapped;
    assign mapped = decode_addr(sfr_addr).hit;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_do == '0));

    // R2
    no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> (pin_oe == '0));

    // R3
    oe_match_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en && sfr_addr == 8'h80) |-> (pin_oe[3:0] == sfr_rdata[7:4]));

    // R4
    bank0_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && sfr_addr == 8'h80) |=> (pin_do[3:0] == $past(sfr_wdata[3:0])));

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && sfr_addr == 8'h80) |-> (sfr_rdata[3:0] == $past(pin_di[3:0], 2)));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && !mapped) |=> ($stable(pin_do) && (port_en == $past(port_en) -> $stable(pin_oe))));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (sfr_rdata == '0));
endmodule

bind gpio_bank gpio_bank_chk u_chk (.*);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    logic        clk = 0;
    logic        rst = 1;
    logic        port_en = 0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [15:0] pin_di, pin_oe, pin_do;
    logic [15:0] ext_val = 16'h0000;

    always #2 clk = ~clk;

    // behavioural pad: driver wins, otherwise the external level
    assign pin_di = (pin_oe & pin_do) | (~pin_oe & ext_val);

    gpio_bank dut (.*);

    typedef struct {
        int          kind;   // 0 rdata, 1 pin_oe, 2 pin_do
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic expect_item(input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1;
        step();
        sfr_we = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        sfr_addr = a;
        expect_item(0, {8'h00, exp}, req);
        step();
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = {8'h00, sfr_rdata};
                1: act = pin_oe;
                default: act = pin_do;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset values
        rd_chk(8'h80, 8'hF0, "R1");
        rd_chk(8'h90, 8'hF0, "R1");
        rd_chk(8'hA0, 8'hF0, "R1");
        rd_chk(8'hB0, 8'hF0, "R1");
        expect_item(2, 16'h0000, "R1"); step();
        // R2 no drive before enable
        expect_item(1, 16'h0000, "R2"); step();
        wr(8'hB0, 8'hFA);
        expect_item(1, 16'h0000, "R2");
        expect_item(2, 16'hA000, "R4"); step();
        wr(8'h80, 8'hF5);
        wr(8'h90, 8'h3C);
        wr(8'hA0, 8'h0F);
        // R3 enable drive
        port_en = 1;
        step();
        expect_item(1, 16'hF03F, "R3");
        expect_item(2, 16'hAFC5, "R3"); step();
        // R7 driven outputs read back their levels
        step(); step();
        rd_chk(8'h80, 8'hF5, "R7");
        rd_chk(8'hB0, 8'hFA, "R7");
        // R6 forced input on group 2, edge-exact latency
        sfr_addr = 8'hA0;
        ext_val[11:8] = 4'h9;
        expect_item(0, 16'h0000, "R6"); step();
        expect_item(0, 16'h0000, "R6"); step();
        expect_item(0, 16'h0009, "R6"); step();
        // R7 mixed group: pins 4,5 drive 0, pins 6,7 external 1,0
        ext_val[7:4] = 4'h5;
        step(); step();
        rd_chk(8'h90, 8'h34, "R7");
        // R8 stray writes
        wr(8'h81, 8'h00);
        wr(8'h00, 8'h00);
        wr(8'hC0, 8'h00);
        expect_item(2, 16'hAFC5, "R8");
        expect_item(1, 16'hF03F, "R8"); step();
        rd_chk(8'h80, 8'hF5, "R8");
        // R9 unmapped reads
        rd_chk(8'h81, 8'h00, "R9");
        rd_chk(8'hFF, 8'h00, "R9");
        rd_chk(8'h00, 8'h00, "R9");
        // R10 enable toggle keeps state
        port_en = 0; step();
        expect_item(1, 16'h0000, "R10"); step();
        port_en = 1; step();
        expect_item(1, 16'hF03F, "R10");
        expect_item(2, 16'hAFC5, "R10"); step();
        // R5 direction readback and mixed input on group 0
        wr(8'h80, 8'h60);
        expect_item(1, 16'hF036, "R5"); step();
        step();
        rd_chk(8'h80, 8'h60, "R5");
        ext_val[3:0] = 4'hF;
        step(); step();
        rd_chk(8'h80, 8'h69, "R6");
        step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule